// File: doc/BRIEF.md
# Port-Pin Edge Interrupt with Clockless Wake

This block gathers interrupt events from a row of external pins for a small microcontroller. While the clock runs, each pin is resynchronised and compared on consecutive clock edges. A transition in the direction chosen for that pin sets a sticky flag. The request line is the OR of all flags whose enable bit is set. Software clears flags by writing ones to a clear port.

A second path keeps working when every clock is stopped. When the sleep indicator goes high, the block freezes the last synchronised level of each pin. From then on, a purely combinational compare raises a wake request as soon as an enabled pin has moved away from that frozen level in its chosen direction. The wake request starts the oscillator. The sticky flag is then set by the clocked path once clock edges return. The oscillator and the processor are outside this block.

Top module: `pin_irq_wake`

## Requirements
- R1: During and after reset, before any pin activity, `flags`, `irq` and `wake` are all 0.
- R2: With `edge_fall[i]`=0, a pin that goes from low to high sets `flags[i]` on the third rising clock edge after the change, and not earlier.
- R3: With `edge_fall[i]`=1, a pin that goes from high to low sets `flags[i]` with the same three-edge latency.
- R4: A steady level, or a transition opposite to the selected direction, never sets a flag.
- R5: A pin level held for at least two clock periods is always caught. A pulse that starts and ends between two rising edges is never seen and sets no flag.
- R6: Flags stay set until cleared. A 1 in bit i of `clr_w1c` during a rising edge clears `flags[i]` only, and 0 bits have no effect.
- R7: If a qualifying edge and a clear of the same bit fall on the same clock edge, the flag ends up set.
- R8: `irq` is 1 exactly when some bit has both `flags[i]` and `irq_en[i]` high. Dropping an enable hides the flag from `irq` but leaves the flag set.
- R9: While `sleep`=1, `wake` rises with no clock edge once an enabled pin differs in its selected direction from the level it had when sleep began. A rising-select pin wakes the block when it goes high from a low snapshot, and a falling-select pin wakes it when it goes low from a high snapshot.
- R10: `wake` is 0 whenever `sleep`=0, and a pin whose `irq_en` bit is 0 never raises `wake`.
- R11: An event that raised `wake` with the clock stopped sets its flag on the third rising edge after the clock restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; may be stopped |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Raw external pin levels |
| irq_en | input | NPINS | Per-pin enable for `irq` and `wake` |
| edge_fall | input | NPINS | Per-pin edge select: 0 rising, 1 falling |
| sleep | input | 1 | High while the device is in sleep |
| clr_w1c | input | NPINS | Write-one-to-clear strobe for `flags` |
| flags | output | NPINS | Sticky per-pin event flags |
| irq | output | 1 | Interrupt request to the processor |
| wake | output | 1 | Clockless wake request to the oscillator |

## Verification
A pin change is counted from the falling clock edge where it is driven. The flag and `irq` are due after the third rising edge that follows. The bench samples them at the falling edge after that third rising edge, and also one falling edge earlier to confirm the flag is not yet set. `wake` is combinational, so it is checked 1 ns after a pin change while the clock is held low. A clear, or a clear that collides with an edge, is driven across exactly one rising edge and read at the next falling edge.

// File: rtl/pin_irq_wake.sv
module pin_irq_wake #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] irq_en,
  input  logic [NPINS-1:0] edge_fall,
  input  logic             sleep,
  input  logic [NPINS-1:0] clr_w1c,
  output logic [NPINS-1:0] flags,
  output logic             irq,
  output logic             wake
);

  logic [NPINS-1:0] sync_a, sync_b, sync_c;
  logic [NPINS-1:0] snap;
  logic [NPINS-1:0] rise_hit, fall_hit, hit;
  logic [NPINS-1:0] moved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      sync_c <= '0;
    end else begin
      sync_a <= pin_in;
      sync_b <= sync_a;
      sync_c <= sync_b;
    end
  end

  assign rise_hit = sync_b & ~sync_c;
  assign fall_hit = ~sync_b & sync_c;
  assign hit      = (rise_hit & ~edge_fall) | (fall_hit & edge_fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_w1c) | hit;
  end

  assign irq = |(flags & irq_en);

  // snapshot tracks the synchronised level while awake and freezes in sleep
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      snap <= '0;
    else if (!sleep) snap <= sync_b;
  end

  assign moved = (~snap & pin_in & ~edge_fall) | (snap & ~pin_in & edge_fall);
  assign wake  = sleep & |(moved & irq_en);

endmodule

// File: rtl/pin_irq_wake_chk.sv
module pin_irq_wake_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] irq_en,
  input logic             sleep,
  input logic [NPINS-1:0] clr_w1c,
  input logic [NPINS-1:0] flags,
  input logic             irq,
  input logic             wake
);

  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  // R4: no flag may appear unless the pin moved in the samples that feed it
  a_r4_level_no_flag: assert property (@(posedge clk) disable iff (!rst_n || age < 3'd5)
    ($past(pin_in, 3) == $past(pin_in, 4)) |-> ((flags & ~$past(flags)) == '0));

  // R6: a cleared bit with a quiet pin is 0 afterwards
  a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n || age < 3'd5)
    ($past(pin_in, 3) == $past(pin_in, 4)) |-> ((flags & $past(clr_w1c)) == '0));

  // R10: no wake while awake
  a_r10_awake_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |-> !wake);

  // R8: all enables low keeps the request low
  a_r8_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq);

  // R1: nothing asserted in reset
  always_comb begin
    if (!rst_n) a_r1_reset_quiet: assert (flags == '0 && !irq) else $error("reset state");
  end

endmodule

bind pin_irq_wake pin_irq_wake_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .irq_en(irq_en), .sleep(sleep),
  .clr_w1c(clr_w1c), .flags(flags), .irq(irq), .wake(wake)
);

// File: tb/pin_irq_wake_tb_top.sv
`timescale 1ns/1ps
module pin_irq_wake_tb_top;
  localparam int N = 8;

  logic clk = 1'b0;
  logic clk_run = 1'b1;
  logic rst_n = 1'b0;
  logic [N-1:0] pin_in = '0, irq_en = '0, edge_fall = '0, clr_w1c = '0;
  logic sleep = 1'b0;
  logic [N-1:0] flags;
  logic irq, wake;
  int runs = 0, fails = 0;

  always begin
    #2.5;
    if (clk_run) clk = ~clk;
  end

  pin_irq_wake #(.NPINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .irq_en(irq_en), .edge_fall(edge_fall),
    .sleep(sleep), .clr_w1c(clr_w1c), .flags(flags), .irq(irq), .wake(wake)
  );

  // {start pins, end pins, falling select, expected flags}
  localparam logic [24:0] VEC [8] = '{
    {8'h00, 8'hFF, 1'b0, 8'hFF},
    {8'hFF, 8'h00, 1'b0, 8'h00},
    {8'hFF, 8'h00, 1'b1, 8'hFF},
    {8'h00, 8'hFF, 1'b1, 8'h00},
    {8'hA5, 8'h5A, 1'b0, 8'h5A},
    {8'hA5, 8'h5A, 1'b1, 8'hA5},
    {8'h0F, 8'hF0, 1'b0, 8'hF0},
    {8'h3C, 8'h3C, 1'b1, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    cyc(5);
    clr_w1c = '1;
    cyc(1);
    clr_w1c = '0;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1 flags in reset", flags, 0);
    chk("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 flags after reset", flags, 0);
    chk("R1 wake after reset", wake, 0);
    irq_en = '1;

    // table: R2 rising, R3 falling, R4 opposite or steady
    for (int k = 0; k < 8; k++) begin
      edge_fall = {N{VEC[k][8]}};
      pin_in = VEC[k][24:17];
      clear_all();
      chk("R1 flags cleared before vector", flags, 0);
      pin_in = VEC[k][16:9];
      cyc(2);
      chk(VEC[k][8] ? "R3 no flag before third edge" : "R2 no flag before third edge", flags, 0);
      cyc(1);
      chk(VEC[k][8] ? "R3/R4 falling vector" : "R2/R4 rising vector", flags, VEC[k][7:0]);
      chk("R8 irq follows flags", irq, VEC[k][7:0] != 0);
      chk("R10 no wake while awake", wake, 0);
    end

    // flags now 00; build 5A again
    edge_fall = '0; pin_in = 8'hA5; clear_all();
    pin_in = 8'h5A; cyc(4);
    chk("R2 setup 5A", flags, 8'h5A);
    irq_en = '0; #0.1;
    chk("R8 irq masked", irq, 0);
    chk("R8 flag kept when masked", flags, 8'h5A);
    irq_en = 8'h02; #0.1;
    chk("R8 single enabled flag", irq, 1);
    irq_en = 8'h01; #0.1;
    chk("R8 enabled bit has no flag", irq, 0);
    irq_en = '1;

    clr_w1c = 8'h02; cyc(1); clr_w1c = '0;
    chk("R6 clear one bit", flags, 8'h58);
    cyc(3);
    chk("R6 sticky", flags, 8'h58);

    // R7 edge wins over simultaneous clear
    pin_in = 8'h00; clear_all();
    pin_in = 8'h01;
    cyc(2);
    clr_w1c = 8'h01;
    cyc(1);
    clr_w1c = '0;
    chk("R7 edge beats clear", flags, 8'h01);

    // R5 short pulse between rising edges
    pin_in = 8'h00; clear_all();
    pin_in = 8'h10; #2; pin_in = 8'h00;
    cyc(5);
    chk("R5 sub-period pulse ignored", flags, 0);
    // R5 two-period pulse
    pin_in = 8'h10; cyc(2); pin_in = 8'h00;
    cyc(3);
    chk("R5 two-period pulse caught", flags & 8'h10, 8'h10);

    // R9 R10 R11 clockless wake
    pin_in = 8'h80; edge_fall = 8'h80; clear_all();
    irq_en = 8'h81;
    cyc(4);
    sleep = 1'b1;
    cyc(2);
    clk_run = 1'b0;
    #1;
    chk("R9 no wake on steady pins", wake, 0);
    pin_in = 8'h82; #1;
    chk("R10 disabled pin no wake", wake, 0);
    pin_in = 8'h83; #1;
    chk("R9 rising enabled pin wakes", wake, 1);
    pin_in = 8'h82; #1;
    chk("R9 wake drops when pin returns", wake, 0);
    pin_in = 8'h02; #1;
    chk("R9 falling enabled pin wakes", wake, 1);
    chk("R11 no flag without clock", flags, 0);
    pin_in = 8'h03;
    #3;
    clk_run = 1'b1;
    cyc(2);
    chk("R11 flag not before third edge", flags, 0);
    cyc(1);
    chk("R11 flag after restart", flags, 8'h83);
    chk("R11 irq after restart", irq, 1);
    sleep = 1'b0; #0.1;
    chk("R10 wake clears when awake", wake, 0);

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule